// File: doc/BRIEF.md
# Performance Event Counter Unit

This block gathers run-time statistics for a processor core. It holds six programmable 32-bit event counters and one 32-bit cycle counter. Software reaches all of them through a small register port with word addresses. Each cycle the core presents an event vector indexed by an 8-bit event code. An event counter adds one on every cycle in which the bit for its programmed code is high. Code 0x00 is kept for software-driven increments.

Software picks one event counter through a select register. A type window and a count window then act on whichever counter is selected. Enables and overflow-interrupt enables are each changed through a pair of registers, one that sets bits and one that clears them. A master enable bit gates every counter. The cycle counter can be slowed to one increment per 64 enabled cycles. On a wrap, a counter raises a sticky overflow flag. The interrupt output asserts while any flag is set and its interrupt enable is on.

Register word addresses (addr_i): 0 control, 1 select, 2 event type (indirect), 3 event count (indirect), 4 cycle count, 5 enable set, 6 enable clear, 7 interrupt-enable set, 8 interrupt-enable clear, 9 overflow flags, 10 software increment, 11 user access. In every mask register, bit x is event counter x and bit 31 is the cycle counter.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset, all counters, enables, interrupt enables, overflow flags and the user bit are 0, and irq_o is low.
- R2: While control bit 0 (master enable) is 0, no counter changes except through a register write, whatever the individual enables hold.
- R3: A write to enable-set (address 5) sets enable bit x for every wdata bit x that is 1. A write to enable-clear (address 6) clears those bits. Bits written as 0 leave their enable unchanged. Reading either address returns the enable mask, and a disabled counter holds its value.
- R4: The select register (address 1, bits [4:0]) picks event counter 0 to 5 for the type window (address 2, code in bits [7:0]) and the count window (address 3). An enabled counter with a nonzero code adds one for each cycle in which event bit [code] is high. For a select value of 6 or more, the windows read 0 and writes to them are ignored.
- R5: The count window and the cycle count register (address 4) can be written. The written value is read back on the next read.
- R6: Writing control with bit 1 set clears all event counters. Writing control with bit 2 set clears the cycle counter and its prescaler. Both bits always read back as 0.
- R7: With control bit 3 set, the cycle counter adds one once per 64 enabled cycles, counted from the last cycle-counter reset.
- R8: A counter that increments from 0xFFFFFFFF wraps to 0 and sets its overflow flag (address 9). Writing 1 to a flag bit clears it, writing 0 leaves it, and a new wrap in the same cycle wins over a clear.
- R9: irq_o is high exactly when some overflow flag is set and its bit in the interrupt-enable mask is set. The mask is changed through set (address 7) and clear (address 8) registers.
- R10: Writing 1 to bit x of the software increment register (address 10) adds one to event counter x only when its code is 0x00, its enable is set and the master enable is set. Event input bit 0 never counts.
- R11: Bit 0 of the user access register (address 11) is readable and writable and drives user_en_o.
- R12: Control bits [15:11] read as the number of event counters, 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| rdata_o | output | 32 | Read data |
| evt_i | input | 256 | Per-cycle event pulses indexed by event code |
| irq_o | output | 1 | Overflow interrupt |
| user_en_o | output | 1 | User access enable bit |

## Verification
Some properties are checked on every cycle. The master-off gate holds every counter still. The enable set and clear writes take effect on the following cycle. The reset bits leave the selected counter group at zero, and a wrap always lands on zero. The cycle overflow flag rises only after a cycle-counter wrap. A full flag clear drops the interrupt, and the user bit follows its write. Other behaviour can only be shown by the scenarios. These include exact event counts for each programmed code, the /64 prescale rate, the software increment conditions, select values outside the counter range, and the write-zero no-op on the set, clear and flag registers.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int unsigned PMU_ADDR_W = 4;
    localparam int unsigned PMU_DATA_W = 32;
    localparam int unsigned CYC_BIT    = 31;

    // control register bit positions
    localparam int unsigned CTL_MASTER  = 0;
    localparam int unsigned CTL_EVRST   = 1;
    localparam int unsigned CTL_CYCRST  = 2;
    localparam int unsigned CTL_DIV     = 3;
    localparam int unsigned CTL_NUM_LSB = 11;
    localparam int unsigned CTL_NUM_W   = 5;

    typedef enum logic [PMU_ADDR_W-1:0] {
        REG_CTRL   = 4'd0,
        REG_SEL    = 4'd1,
        REG_EVTYPE = 4'd2,
        REG_EVCNT  = 4'd3,
        REG_CYCCNT = 4'd4,
        REG_ENSET  = 4'd5,
        REG_ENCLR  = 4'd6,
        REG_IRQSET = 4'd7,
        REG_IRQCLR = 4'd8,
        REG_OVF    = 4'd9,
        REG_SWINC  = 4'd10,
        REG_USER   = 4'd11
    } pmu_reg_e;
endpackage

// File: rtl/pmu_count_slice.sv
module pmu_count_slice #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } slice_t;

    slice_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (step_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = step_i && !clr_i && !load_i && (&st_q.cnt);

    // R8: a wrap always leaves the counter at zero
    a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));
endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
    parameter int unsigned DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic div_en_i,
    input  logic clr_i,
    output logic step_o
);
    typedef struct packed {
        logic [DIV_LOG2-1:0] pre;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.pre = '0;
        end else if (tick_i && div_en_i) begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_o = tick_i && (!div_en_i || (&st_q.pre));

    // R2: no cycle step without an enabled tick
    a_r2_no_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |-> !step_o);
endmodule

// File: rtl/pmu_event_route.sv
module pmu_event_route #(
    parameter int unsigned N_CNT   = 6,
    parameter int unsigned CODE_W  = 8,
    parameter int unsigned NUM_EVT = 256
) (
    input  logic [NUM_EVT-1:0]           evt_i,
    input  logic [N_CNT-1:0][CODE_W-1:0] code_i,
    input  logic [N_CNT-1:0]             en_i,
    input  logic                         master_i,
    input  logic [N_CNT-1:0]             swinc_i,
    output logic [N_CNT-1:0]             step_o
);
    for (genvar i = 0; i < N_CNT; i++) begin : g_route
        logic is_sw;
        logic hit;
        assign is_sw     = (code_i[i] == '0);
        assign hit       = is_sw ? swinc_i[i] : evt_i[code_i[i]];
        assign step_o[i] = master_i && en_i[i] && hit;
    end
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
    import pmu_pkg::*;
#(
    parameter int unsigned N_CNT    = 6,
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned DIV_LOG2 = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic                  rd_en_i,
    input  logic [PMU_ADDR_W-1:0] addr_i,
    input  logic [PMU_DATA_W-1:0] wdata_i,
    output logic                  rd_valid_o,
    output logic [PMU_DATA_W-1:0] rdata_o,
    input  logic [(1<<CODE_W)-1:0] evt_i,
    output logic                  irq_o,
    output logic                  user_en_o
);
    localparam int unsigned NUM_EVT = 1 << CODE_W;
    localparam int unsigned CNT_W   = PMU_DATA_W;
    localparam int unsigned IDX_W   = (N_CNT > 1) ? $clog2(N_CNT) : 1;
    localparam int unsigned SEL_W   = 5;

    typedef struct packed {
        logic                         master;
        logic                         div_en;
        logic [SEL_W-1:0]             sel;
        logic [N_CNT-1:0][CODE_W-1:0] code;
        logic [N_CNT-1:0]             ev_en;
        logic                         cyc_en;
        logic [N_CNT-1:0]             ev_irq;
        logic                         cyc_irq;
        logic [N_CNT-1:0]             ev_ovf;
        logic                         cyc_ovf;
        logic                         user_en;
        logic                         rd_valid;
        logic [PMU_DATA_W-1:0]        rd_data;
    } unit_t;

    unit_t st_d, st_q;

    // register decode
    logic wr_ctrl, wr_sel, wr_type, wr_evcnt, wr_cyccnt, wr_enset, wr_enclr;
    logic wr_irqset, wr_irqclr, wr_ovf, wr_swinc, wr_user;
    assign wr_ctrl   = wr_en_i && (addr_i == REG_CTRL);
    assign wr_sel    = wr_en_i && (addr_i == REG_SEL);
    assign wr_type   = wr_en_i && (addr_i == REG_EVTYPE);
    assign wr_evcnt  = wr_en_i && (addr_i == REG_EVCNT);
    assign wr_cyccnt = wr_en_i && (addr_i == REG_CYCCNT);
    assign wr_enset  = wr_en_i && (addr_i == REG_ENSET);
    assign wr_enclr  = wr_en_i && (addr_i == REG_ENCLR);
    assign wr_irqset = wr_en_i && (addr_i == REG_IRQSET);
    assign wr_irqclr = wr_en_i && (addr_i == REG_IRQCLR);
    assign wr_ovf    = wr_en_i && (addr_i == REG_OVF);
    assign wr_swinc  = wr_en_i && (addr_i == REG_SWINC);
    assign wr_user   = wr_en_i && (addr_i == REG_USER);

    logic             sel_ok;
    logic [IDX_W-1:0] sel_idx;
    assign sel_ok  = (st_q.sel < SEL_W'(N_CNT));
    assign sel_idx = st_q.sel[IDX_W-1:0];

    logic             ev_clr, cyc_clr;
    logic [N_CNT-1:0] wmask_ev;
    logic             wmask_cyc;
    assign ev_clr    = wr_ctrl && wdata_i[CTL_EVRST];
    assign cyc_clr   = wr_ctrl && wdata_i[CTL_CYCRST];
    assign wmask_ev  = wdata_i[N_CNT-1:0];
    assign wmask_cyc = wdata_i[CYC_BIT];

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    // counter datapath
    logic [N_CNT-1:0][CNT_W-1:0] ev_cnt;
    logic [N_CNT-1:0]            ev_step, ev_wrap, ev_load;
    logic [N_CNT-1:0]            swinc;
    logic [CNT_W-1:0]            cyc_cnt;
    logic                        cyc_step, cyc_wrap;

    assign swinc = wr_swinc ? wmask_ev : '0;

    pmu_event_route #(
        .N_CNT  (N_CNT),
        .CODE_W (CODE_W),
        .NUM_EVT(NUM_EVT)
    ) u_route (
        .evt_i   (evt_i),
        .code_i  (st_q.code),
        .en_i    (st_q.ev_en),
        .master_i(st_q.master),
        .swinc_i (swinc),
        .step_o  (ev_step)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_evcnt
        assign ev_load[i] = wr_evcnt && sel_ok && (st_q.sel == SEL_W'(i));
        pmu_count_slice #(.WIDTH(CNT_W)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_i    (ev_step[i]),
            .clr_i     (ev_clr),
            .load_i    (ev_load[i]),
            .load_val_i(wdata_i),
            .cnt_o     (ev_cnt[i]),
            .wrap_o    (ev_wrap[i])
        );
    end

    pmu_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (st_q.master && st_q.cyc_en),
        .div_en_i(st_q.div_en),
        .clr_i   (cyc_clr),
        .step_o  (cyc_step)
    );

    pmu_count_slice #(.WIDTH(CNT_W)) u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (cyc_step),
        .clr_i     (cyc_clr),
        .load_i    (wr_cyccnt),
        .load_val_i(wdata_i),
        .cnt_o     (cyc_cnt),
        .wrap_o    (cyc_wrap)
    );

    function automatic logic [PMU_DATA_W-1:0] pack_mask(input logic [N_CNT-1:0] ev,
                                                       input logic cyc);
        logic [PMU_DATA_W-1:0] m;
        m = '0;
        m[N_CNT-1:0] = ev;
        m[CYC_BIT]   = cyc;
        return m;
    endfunction

    always_comb begin
        st_d = st_q;

        if (wr_ctrl) begin
            st_d.master = wdata_i[CTL_MASTER];
            st_d.div_en = wdata_i[CTL_DIV];
        end
        if (wr_sel) st_d.sel = wdata_i[SEL_W-1:0];
        if (wr_type && sel_ok) st_d.code[sel_idx] = wdata_i[CODE_W-1:0];

        st_d.ev_en  = (st_q.ev_en  | (wr_enset ? wmask_ev  : '0))   & ~(wr_enclr ? wmask_ev  : '0);
        st_d.cyc_en = (st_q.cyc_en | (wr_enset && wmask_cyc))       & ~(wr_enclr && wmask_cyc);
        st_d.ev_irq = (st_q.ev_irq | (wr_irqset ? wmask_ev : '0))   & ~(wr_irqclr ? wmask_ev : '0);
        st_d.cyc_irq = (st_q.cyc_irq | (wr_irqset && wmask_cyc))    & ~(wr_irqclr && wmask_cyc);

        st_d.ev_ovf  = (st_q.ev_ovf & ~(wr_ovf ? wmask_ev : '0)) | ev_wrap;
        st_d.cyc_ovf = (st_q.cyc_ovf & ~(wr_ovf && wmask_cyc)) | cyc_wrap;

        if (wr_user) st_d.user_en = wdata_i[0];

        st_d.rd_valid = rd_en_i;
        st_d.rd_data  = '0;
        if (rd_en_i) begin
            case (addr_i)
                REG_CTRL: begin
                    st_d.rd_data[CTL_MASTER] = st_q.master;
                    st_d.rd_data[CTL_DIV]    = st_q.div_en;
                    st_d.rd_data[CTL_NUM_LSB +: CTL_NUM_W] = CTL_NUM_W'(N_CNT);
                end
                REG_SEL:    st_d.rd_data[SEL_W-1:0] = st_q.sel;
                REG_EVTYPE: if (sel_ok) st_d.rd_data[CODE_W-1:0] = st_q.code[sel_idx];
                REG_EVCNT:  if (sel_ok) st_d.rd_data = ev_cnt[sel_idx];
                REG_CYCCNT: st_d.rd_data = cyc_cnt;
                REG_ENSET, REG_ENCLR:   st_d.rd_data = pack_mask(st_q.ev_en, st_q.cyc_en);
                REG_IRQSET, REG_IRQCLR: st_d.rd_data = pack_mask(st_q.ev_irq, st_q.cyc_irq);
                REG_OVF:    st_d.rd_data = pack_mask(st_q.ev_ovf, st_q.cyc_ovf);
                REG_USER:   st_d.rd_data[0] = st_q.user_en;
                default:    st_d.rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid_o = st_q.rd_valid;
    assign rdata_o    = st_q.rd_data;
    assign irq_o      = (|(st_q.ev_ovf & st_q.ev_irq)) || (st_q.cyc_ovf && st_q.cyc_irq);
    assign user_en_o  = st_q.user_en;

    // R2: master off and no write -> every counter holds
    a_r2_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.master && !wr_en_i) |=> ($stable(ev_cnt) && $stable(cyc_cnt)));

    // R3: set writes turn the written enables on
    a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enset |=> ((st_q.ev_en & $past(wmask_ev)) == $past(wmask_ev)));

    // R3: clear writes turn the written enables off
    a_r3_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enclr |=> ((st_q.ev_en & $past(wmask_ev)) == '0));

    // R6: event reset leaves all event counters at zero
    a_r6_event_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ev_clr |=> (ev_cnt == '0));

    // R6: cycle reset leaves the cycle counter at zero
    a_r6_cycle_reset: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_clr |=> (cyc_cnt == '0));

    // R8: the cycle flag only rises after a cycle-counter wrap
    a_r8_cyc_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.cyc_ovf) |-> $past(cyc_wrap));

    // R9: clearing every flag with no new wrap drops the interrupt
    a_r9_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ovf && (&wmask_ev) && wmask_cyc && !(|ev_wrap) && !cyc_wrap) |=> !irq_o);

    // R11: the user bit follows its write
    a_r11_user_bit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_user |=> (user_en_o == $past(wdata_i[0])));
endmodule

// File: tb/pmu_counter_unit_tb.sv
module pmu_counter_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        rd_valid;
    logic [31:0] rdata;
    logic [255:0] evt = '0;
    logic        irq;
    logic        user_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    pmu_counter_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rd_valid_o(rd_valid),
        .rdata_o   (rdata),
        .evt_i     (evt),
        .irq_o     (irq),
        .user_en_o (user_en)
    );

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic pulse(input int code, input int n);
        @(negedge clk);
        evt[code] = 1'b1;
        repeat (n) @(negedge clk);
        evt[code] = 1'b0;
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        @(negedge clk);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read: actual %h expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R12: reset state
        rd(4'd0, 32'h0000_3000, "R1 R12 control after reset");
        rd(4'd5, 32'h0, "R1 enables after reset");
        rd(4'd9, 32'h0, "R1 flags after reset");
        rd(4'd4, 32'h0, "R1 cycle count after reset");
        check_bit(irq, 1'b0, "R1 irq after reset");
        check_bit(user_en, 1'b0, "R1 user bit after reset");

        // R4: program codes
        wr(4'd1, 32'd0); wr(4'd2, 32'h05);
        wr(4'd1, 32'd1); wr(4'd2, 32'h09);
        rd(4'd2, 32'h09, "R4 type readback");
        wr(4'd5, 32'h3);
        rd(4'd6, 32'h3, "R3 enable mask via clear address");

        // R2: master off
        pulse(5, 4);
        wr(4'd1, 32'd0);
        rd(4'd3, 32'd0, "R2 no count while master off");

        // R4: counting per code
        wr(4'd0, 32'h1);
        pulse(5, 4);
        pulse(9, 3);
        rd(4'd3, 32'd4, "R4 counter0 code 5");
        wr(4'd1, 32'd1);
        rd(4'd3, 32'd3, "R4 counter1 code 9");

        // R3: clear, zero no-op, hold
        wr(4'd6, 32'h1);
        wr(4'd6, 32'h0);
        rd(4'd5, 32'h2, "R3 clear bit0 and zero no-op");
        wr(4'd1, 32'd0);
        pulse(5, 2);
        rd(4'd3, 32'd4, "R3 disabled counter holds");

        // R6: event reset
        wr(4'd0, 32'h3);
        rd(4'd3, 32'd0, "R6 event counters cleared");
        rd(4'd0, 32'h0000_3001, "R6 reset bits read zero");

        // R5: cycle counter load and count
        wr(4'd4, 32'd100);
        rd(4'd4, 32'd100, "R5 cycle count load");
        wr(4'd5, 32'h8000_0000);
        repeat (9) @(negedge clk);
        wr(4'd6, 32'h8000_0000);
        rd(4'd4, 32'd110, "R5 cycle count after 10 cycles");
        rd(4'd5, 32'h2, "R3 cycle bit leaves event enables");

        // R7: prescale
        wr(4'd0, 32'hD);
        rd(4'd4, 32'd0, "R6 cycle reset");
        wr(4'd5, 32'h8000_0000);
        repeat (129) @(negedge clk);
        wr(4'd6, 32'h8000_0000);
        rd(4'd4, 32'd2, "R7 130 ticks divided by 64");
        wr(4'd0, 32'h1);

        // R8 / R9: event overflow
        wr(4'd1, 32'd1);
        wr(4'd3, 32'hFFFF_FFFE);
        rd(4'd3, 32'hFFFF_FFFE, "R5 count window load");
        wr(4'd7, 32'h2);
        pulse(9, 2);
        rd(4'd3, 32'd0, "R8 wrap to zero");
        rd(4'd9, 32'h2, "R8 flag set");
        check_bit(irq, 1'b1, "R9 irq on enabled flag");
        wr(4'd9, 32'h0);
        rd(4'd9, 32'h2, "R8 write zero keeps flag");
        wr(4'd9, 32'h2);
        rd(4'd9, 32'h0, "R8 write one clears flag");
        check_bit(irq, 1'b0, "R9 irq drops with flag");
        wr(4'd8, 32'h2);
        rd(4'd7, 32'h0, "R9 irq mask cleared");
        wr(4'd3, 32'hFFFF_FFFF);
        pulse(9, 1);
        rd(4'd9, 32'h2, "R8 flag again");
        check_bit(irq, 1'b0, "R9 masked flag no irq");
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, 32'h0, "R8 all flags cleared");

        // R8 / R9: cycle overflow
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd7, 32'h8000_0000);
        wr(4'd5, 32'h8000_0000);
        wr(4'd6, 32'h8000_0000);
        rd(4'd9, 32'h8000_0000, "R8 cycle flag");
        rd(4'd4, 32'd0, "R8 cycle wrap to zero");
        check_bit(irq, 1'b1, "R9 irq on cycle flag");
        wr(4'd9, 32'h8000_0000);
        check_bit(irq, 1'b0, "R9 irq after cycle clear");

        // R10: software increment
        wr(4'd1, 32'd2); wr(4'd2, 32'h0);
        wr(4'd5, 32'h4);
        wr(4'd10, 32'h4); wr(4'd10, 32'h4);
        rd(4'd3, 32'd2, "R10 two soft increments");
        pulse(0, 3);
        rd(4'd3, 32'd2, "R10 event bit 0 ignored");
        wr(4'd10, 32'h2);
        wr(4'd1, 32'd1);
        rd(4'd3, 32'd0, "R10 nonzero code ignores soft inc");
        wr(4'd1, 32'd2);
        wr(4'd6, 32'h4);
        wr(4'd10, 32'h4);
        rd(4'd3, 32'd2, "R10 disabled counter ignores soft inc");
        wr(4'd0, 32'h0);
        wr(4'd5, 32'h4);
        wr(4'd10, 32'h4);
        rd(4'd3, 32'd2, "R10 master off ignores soft inc");
        wr(4'd0, 32'h1);

        // R4: select out of range
        wr(4'd1, 32'd9);
        rd(4'd1, 32'd9, "R4 select readback");
        wr(4'd2, 32'h33);
        wr(4'd3, 32'h55);
        rd(4'd2, 32'h0, "R4 out-of-range type reads zero");
        rd(4'd3, 32'h0, "R4 out-of-range count reads zero");
        wr(4'd1, 32'd1);
        rd(4'd2, 32'h09, "R4 counter1 type untouched");
        rd(4'd3, 32'h0, "R4 counter1 count untouched");

        // R11: user bit
        wr(4'd11, 32'h1);
        check_bit(user_en, 1'b1, "R11 user bit set");
        rd(4'd11, 32'h1, "R11 user readback");
        wr(4'd11, 32'h0);
        check_bit(user_en, 1'b0, "R11 user bit cleared");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule